// File: doc/BRIEF.md
# Cascadable 4-to-16 Line Decoder with Mixed-Polarity Selects

This block turns a 4-bit binary code into sixteen active-low select lines, of which at most one is low at a time. It is built from two identical 3-to-8 leaf decoders. Each leaf has three chip-select inputs: two that are active when low and one that is active when high. A leaf drives an output low only while all three selects are at their active levels. Otherwise it holds all eight of its lines high.

The top level joins the two leaves without an inverter. The most significant code bit feeds an active-low select of the lower leaf and the active-high select of the upper leaf, so exactly one leaf is on for any code. The three lower code bits go to both leaves in parallel. Line k of the lower leaf becomes combined line k, and line k of the upper leaf becomes combined line k+8. A single active-low enable reaches a spare active-low select on each leaf and can switch the whole decoder off.

The block is purely combinational. It is meant for address or chip-select decoding inside a larger design.

Top module: `xdec16`

## Requirements
- R1: While `en_n_i` is 1, all sixteen bits of `lines_n_o` are 1, whatever the value of `code_i`.
- R2: While `en_n_i` is 0, exactly one bit of `lines_n_o` is 0, and it sits at bit position `code_i` (treated as an unsigned number from 0 to 15). This holds for an ascending sweep of the code and for a descending one.
- R3: While `en_n_i` is 0 and `code_i[3]` is 1, bits 7..0 of `lines_n_o` are all 1.
- R4: While `en_n_i` is 0 and `code_i[3]` is 0, bits 15..8 of `lines_n_o` are all 1.
- R5: A leaf decoder drives any output low only when its first active-low select is 0, its second active-low select is 0 and its active-high select is 1. For the other seven select combinations, all eight outputs are 1.
- R6: When all three selects of a leaf are active, exactly one leaf output is 0, at the bit position given by its 3-bit address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code_i | input | 4 | Binary code to decode. Bit 3 picks the upper or lower leaf; bits 2..0 go to both leaves. |
| en_n_i | input | 1 | Active-low enable for the whole decoder. |
| lines_n_o | output | 16 | Active-low one-hot select lines. Bit n is low for code n. |

## Verification
The assertions check the decode only when every input is a known 0 or 1. They skip any evaluation in which a code bit, the enable or a chip select is X or Z, because the one-hot properties have no meaning on unknown inputs.

The bench never leaves an input undriven once the run starts. It changes inputs only on the falling clock edge and samples the outputs two nanoseconds later, after the combinational paths have settled.

The sweeps cover all sixteen codes with the decoder disabled, then an ascending and a descending count with it enabled. A separate leaf instance is driven through all sixty-four combinations of select and address.

// File: rtl/xdec_pkg.sv
package xdec_pkg;

    // Default address width of one leaf decoder.
    localparam int unsigned LEAF_AW = 3;

    // The three chip selects of a leaf: two active-low, one active-high.
    typedef struct packed {
        logic low_a;   // active when 0
        logic low_b;   // active when 0
        logic high;    // active when 1
    } chipsel_t;

    // True only when every select is at its active level.
    function automatic logic cs_enabled(chipsel_t cs);
        return (!cs.low_a) && (!cs.low_b) && cs.high;
    endfunction

    // Chip selects for one half of a cascaded pair.
    // Half 0 is turned on by a 0 on the steering bit; half 1 by a 1.
    // The steering bit lands on a select of matching polarity, so no inverter is needed.
    function automatic chipsel_t half_select(int unsigned half, logic steer, logic en_n);
        chipsel_t cs;
        if (half == 0) begin
            cs.low_a = steer;
            cs.low_b = en_n;
            cs.high  = 1'b1;
        end else begin
            cs.low_a = en_n;
            cs.low_b = 1'b0;
            cs.high  = steer;
        end
        return cs;
    endfunction

endpackage

// File: rtl/xdec_onehot.sv
module xdec_onehot #(
    parameter int unsigned AW = 3,
    localparam int unsigned NL = 1 << AW
) (
    input  logic [AW-1:0] idx_i,
    output logic [NL-1:0] hot_o
);

    // One comparator per line; the line matching the index goes high.
    for (genvar k = 0; k < NL; k++) begin : g_line
        assign hot_o[k] = (idx_i == AW'(k));
    end

endmodule

// File: rtl/xdec_leaf.sv
module xdec_leaf
    import xdec_pkg::*;
#(
    parameter int unsigned AW = LEAF_AW,
    localparam int unsigned NL = 1 << AW
) (
    input  logic [AW-1:0] addr_i,
    input  chipsel_t      cs_i,
    output logic [NL-1:0] y_n_o
);

    logic [NL-1:0] hot;
    logic          on;

    xdec_onehot #(.AW(AW)) u_hot (
        .idx_i (addr_i),
        .hot_o (hot)
    );

    assign on = cs_enabled(cs_i);

    // Outputs are active-low; a leaf that is off parks every line high.
    always_comb begin
        if (on) y_n_o = ~hot;
        else    y_n_o = '1;
    end

    // Checks on the leaf, evaluated only on known inputs.
    always_comb begin
        if (!$isunknown({addr_i, cs_i})) begin
            // R5: any low output implies all three selects are active
            a_r5_gate_all_selects: assert ((&y_n_o) || (!cs_i.low_a && !cs_i.low_b && cs_i.high))
                else $error("leaf drove a line while a select was inactive");
            // R6: when fully selected, a single zero at the address
            if (!cs_i.low_a && !cs_i.low_b && cs_i.high) begin
                a_r6_single_low: assert ($countones(~y_n_o) == 1 && y_n_o[addr_i] == 1'b0)
                    else $error("leaf output not one-cold at the address");
            end
        end
    end

endmodule

// File: rtl/xdec16.sv
module xdec16
    import xdec_pkg::*;
#(
    parameter int unsigned AW = LEAF_AW,
    localparam int unsigned NL = 1 << AW,
    localparam int unsigned CW = AW + 1,
    localparam int unsigned NT = 2 * NL
) (
    input  logic [CW-1:0] code_i,
    input  logic          en_n_i,
    output logic [NT-1:0] lines_n_o
);

    logic          steer;
    logic [AW-1:0] sub_addr;

    assign steer    = code_i[CW-1];
    assign sub_addr = code_i[AW-1:0];

    // Two leaves; the top code bit steers through opposite-polarity selects.
    for (genvar h = 0; h < 2; h++) begin : g_half
        chipsel_t cs;
        assign cs = half_select(h, steer, en_n_i);

        xdec_leaf #(.AW(AW)) u_leaf (
            .addr_i (sub_addr),
            .cs_i   (cs),
            .y_n_o  (lines_n_o[h*NL +: NL])
        );
    end

    // Checks on the combined lines, evaluated only on known inputs.
    always_comb begin
        if (!$isunknown({code_i, en_n_i})) begin
            // R1: a disabled decoder keeps every line high
            a_r1_disabled_idle: assert (en_n_i == 1'b0 || (&lines_n_o))
                else $error("line low while disabled");
            if (en_n_i == 1'b0) begin
                // R2: one line low, at the code
                a_r2_one_cold: assert ($onehot(~lines_n_o) && lines_n_o[code_i] == 1'b0)
                    else $error("combined lines not one-cold at the code");
                // R3 / R4: the idle half stays fully high
                a_r3_low_half_idle: assert (!steer || (&lines_n_o[NL-1:0]))
                    else $error("lower half active with top bit set");
                a_r4_high_half_idle: assert (steer || (&lines_n_o[NT-1:NL]))
                    else $error("upper half active with top bit clear");
            end
        end
    end

endmodule

// File: tb/xdec16_bench.sv
module xdec16_bench;
    import xdec_pkg::*;

    logic        clk = 1'b0;
    logic [3:0]  code;
    logic        en_n;
    logic [15:0] lines_n;

    logic [2:0]  leaf_addr;
    chipsel_t    leaf_cs;
    logic [7:0]  leaf_y_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    xdec16 u_xdec16 (
        .code_i    (code),
        .en_n_i    (en_n),
        .lines_n_o (lines_n)
    );

    xdec_leaf u_leaf (
        .addr_i (leaf_addr),
        .cs_i   (leaf_cs),
        .y_n_o  (leaf_y_n)
    );

    task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_top(logic [3:0] c, logic e);
        @(negedge clk);
        code = c;
        en_n = e;
        #2;
    endtask

    task automatic check_enabled(int c);
        logic [15:0] exp;
        exp = ~(16'd1 << c);
        check16("R2", lines_n, exp);
        if (c >= 8) check16("R3", {8'hff, lines_n[7:0]}, 16'hffff);
        else        check16("R4", {lines_n[15:8], 8'hff}, 16'hffff);
    endtask

    initial begin
        code = '0; en_n = 1'b1; leaf_addr = '0; leaf_cs = '{low_a: 1'b1, low_b: 1'b1, high: 1'b0};

        // R1: disabled, every code
        for (int c = 0; c < 16; c++) begin
            drive_top(4'(c), 1'b1);
            check16("R1", lines_n, 16'hffff);
        end

        // R2/R3/R4: ascending count
        for (int c = 0; c < 16; c++) begin
            drive_top(4'(c), 1'b0);
            check_enabled(c);
        end

        // R2/R3/R4: descending count
        for (int c = 15; c >= 0; c--) begin
            drive_top(4'(c), 1'b0);
            check_enabled(c);
        end

        // R1: enable withdrawn after an active code
        drive_top(4'd9, 1'b1);
        check16("R1", lines_n, 16'hffff);

        // R5/R6: leaf, every select combination and address
        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < 8; a++) begin
                logic on;
                @(negedge clk);
                leaf_cs   = '{low_a: s[2], low_b: s[1], high: s[0]};
                leaf_addr = 3'(a);
                #2;
                on = (s[2] == 1'b0) && (s[1] == 1'b0) && (s[0] == 1'b1);
                if (on) check8("R6", leaf_y_n, ~(8'd1 << a));
                else    check8("R5", leaf_y_n, 8'hff);
            end
        end

        done = 1'b1;
    end

    initial begin : watchdog
        int cyc;
        for (cyc = 0; cyc < 20000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule